// File: doc/BRIEF.md
# Dual JTAG Port Mode Switch

This block joins three parties: a JTAG port facing a backplane (the primary port), a JTAG port driving the board's own scan chain (the secondary port), and a small host register bus with 8 data bits and 4 address bits. It has two operating modes. In slave mode the backplane tester owns the board chain: the primary TCK, TMS, TDI and TRST pass straight through to the secondary outputs, and the chain's TDO is returned on the primary TDO pin. In master mode each port becomes an independent JTAG master. Its pins are driven from a host-writable drive register, and the TDO of each port is sampled into a register the host can read.

Each primary pin is split into an input, an output and an output enable, so that the pad ring can build the bidirectional buffers. The direction of every primary pin follows the mode. Reset always returns the block to slave mode. Master mode is entered only by a host write. On every mode change both drive registers are forced to the JTAG idle levels for one cycle before the pin directions swap. A global active-low test output enable removes every output drive.

The host bus is a plain strobe interface, not a stream, so it has no valid/ready handshake and no back-pressure. The chip select and the read and write strobes are synchronised to `clk`. A write takes effect when the synchronised write strobe is released. Address and data must stay stable until a few cycles after the strobes rise.

Top module: `jtag_mode_switch`

## Requirements
- R1: While `rst_n` is low, and after its release, the block is in slave mode. Both drive registers reset to idle 0x0E (bit0 TCK=0, bit1 TMS=1, bit2 TDI=1, bit3 TRST=1). The mode register at address 0x0 reads 0.
- R2: In slave mode, `sec_tck_o`, `sec_tms_o`, `sec_tdi_o` and `sec_trst_o` follow `pri_tck_i`, `pri_tms_i`, `pri_tdi_i` and `pri_trst_i` combinationally.
- R3: In slave mode, `pri_tdo_o` follows `sec_tdo_i`, `pri_tdo_oe` is 1 and `pri_ctl_oe` is 0 (while `toe_n` is high).
- R4: Only a write to address 0x0 with data bit0=1 enters master mode. Writing bit0=0, writing to another address, or strobing with `host_cs_n` high leaves the mode unchanged.
- R5: In master mode, `pri_tck_o`, `pri_tms_o`, `pri_tdi_o` and `pri_trst_o` carry bits 0, 1, 2 and 3 of the primary drive register (address 0x1). `pri_ctl_oe` is 1 and `pri_tdo_oe` is 0.
- R6: In master mode, the secondary outputs carry the same bit layout from the secondary drive register (address 0x2). They do not depend on the primary inputs.
- R7: `slave_n` is low exactly in slave mode and `master_n` is low exactly in master mode.
- R8: `pri_tdo_drv_n` is low only in slave mode.
- R9: `sec_awr_n_o` follows `pri_awr_n_i` in slave mode and is held high in master mode.
- R10: With `toe_n` low, `pri_ctl_oe`, `pri_tdo_oe`, `sec_oe`, `misc_oe` and `host_rdata_oe` are all 0.
- R11: Address 0x3 is read-only. It returns bit0 = captured primary TDO, bit1 = captured secondary TDO, bit2 = 1 in master mode, and 0 in the other bits. Both TDO inputs are sampled on every clock while in master mode.
- R12: When a write changes the mode, both drive registers read 0x0E from then on. The master outputs hold that idle value in the last cycle before the mode, and with it the pin direction, changes. Drive registers and the mode register read back at their own addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low reset, forces slave mode |
| toe_n | input | 1 | Active-low global output enable |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_addr | input | 4 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| host_rdata_oe | output | 1 | Read data bus drive enable |
| pri_tck_i | input | 1 | Primary TCK pad input |
| pri_tms_i | input | 1 | Primary TMS pad input |
| pri_tdi_i | input | 1 | Primary TDI pad input |
| pri_trst_i | input | 1 | Primary TRST pad input |
| pri_tdo_i | input | 1 | Primary TDO pad input |
| pri_tck_o | output | 1 | Primary TCK pad output |
| pri_tms_o | output | 1 | Primary TMS pad output |
| pri_tdi_o | output | 1 | Primary TDI pad output |
| pri_trst_o | output | 1 | Primary TRST pad output |
| pri_tdo_o | output | 1 | Primary TDO pad output |
| pri_ctl_oe | output | 1 | Enable for primary TCK/TMS/TDI/TRST outputs |
| pri_tdo_oe | output | 1 | Enable for primary TDO output |
| pri_awr_n_i | input | 1 | Primary auto-write strobe, low = write pulse |
| sec_tck_o | output | 1 | Secondary TCK |
| sec_tms_o | output | 1 | Secondary TMS |
| sec_tdi_o | output | 1 | Secondary TDI (to chain) |
| sec_trst_o | output | 1 | Secondary TRST |
| sec_tdo_i | input | 1 | Secondary TDO (from chain) |
| sec_awr_n_o | output | 1 | Secondary auto-write strobe |
| sec_oe | output | 1 | Enable for all secondary outputs |
| slave_n | output | 1 | Low while in slave mode |
| master_n | output | 1 | Low while in master mode |
| pri_tdo_drv_n | output | 1 | Extra-drive strobe for primary TDO, low in slave mode |
| misc_oe | output | 1 | Enable for status and drive-strobe outputs |

## Verification
The assertions check on every cycle that the primary TDI and TDO pins are never both driven, and that every output enable is off while `toe_n` is low. They also check that the extra-drive strobe is only active in slave mode, that the mode changes only two cycles after a decoded write, and that both drive registers hold idle whenever the mode changes. The bench scenarios cover what the assertions cannot. These are the pass-through values under random pin patterns, the drive-register bit mapping on both ports, and the independence of the secondary port from the primary inputs. They also cover the writes that must not change the mode, the captured TDO values read back at 0x3, and the idle levels actually seen on the primary pins just before a return to slave mode.

// File: rtl/jms_pkg.sv
package jms_pkg;
  typedef enum logic {
    MODE_SLAVE  = 1'b0,
    MODE_MASTER = 1'b1
  } jms_mode_e;

  // drive register layout, LSB first: tck, tms, tdi, trst
  typedef struct packed {
    logic trst;
    logic tdi;
    logic tms;
    logic tck;
  } jdrv_t;

  localparam jdrv_t DRV_IDLE = '{trst: 1'b1, tdi: 1'b1, tms: 1'b1, tck: 1'b0};

  localparam int unsigned REG_MODE = 0;
  localparam int unsigned REG_PDRV = 1;
  localparam int unsigned REG_SDRV = 2;
  localparam int unsigned REG_STAT = 3;
endpackage

// File: rtl/jms_host_sync.sv
module jms_host_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic wr_evt,
  output logic rd_act
);
  localparam int unsigned SW = SYNC_STAGES + 1;

  logic [SW-1:0] wr_sh;
  logic [SW-1:0] rd_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_sh <= '0;
      rd_sh <= '0;
    end else begin
      wr_sh <= {wr_sh[SW-2:0], ~cs_n & ~wr_n};
      rd_sh <= {rd_sh[SW-2:0], ~cs_n & ~rd_n};
    end
  end

  // release of the synchronised write strobe
  assign wr_evt = wr_sh[SW-1] & ~wr_sh[SW-2];
  assign rd_act = rd_sh[SW-2];

  // R4
  wr_evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> !wr_evt);
endmodule

// File: rtl/jms_mode_regs.sv
module jms_mode_regs
  import jms_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_evt,
  input  logic [AW-1:0] addr,
  input  logic [3:0]    wbits,
  input  logic          pri_tdo_i,
  input  logic          sec_tdo_i,
  output jms_mode_e     mode,
  output jdrv_t         pdrv,
  output jdrv_t         sdrv,
  output logic          cap_pri,
  output logic          cap_sec
);
  jms_mode_e mode_q, tgt_q;
  logic      pend_q;
  jdrv_t     pdrv_q, sdrv_q;
  logic      cap_pri_q, cap_sec_q;
  jms_mode_e wr_mode;

  assign wr_mode = wbits[0] ? MODE_MASTER : MODE_SLAVE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_SLAVE;
      tgt_q     <= MODE_SLAVE;
      pend_q    <= 1'b0;
      pdrv_q    <= DRV_IDLE;
      sdrv_q    <= DRV_IDLE;
      cap_pri_q <= 1'b0;
      cap_sec_q <= 1'b0;
    end else begin
      if (pend_q) begin
        mode_q <= tgt_q;
        pend_q <= 1'b0;
      end
      if (wr_evt) begin
        if (addr == AW'(REG_MODE)) begin
          if (wr_mode != mode_q) begin
            // park both masters at idle one cycle before directions move
            pend_q <= 1'b1;
            tgt_q  <= wr_mode;
            pdrv_q <= DRV_IDLE;
            sdrv_q <= DRV_IDLE;
          end
        end else if (addr == AW'(REG_PDRV)) begin
          pdrv_q <= jdrv_t'(wbits);
        end else if (addr == AW'(REG_SDRV)) begin
          sdrv_q <= jdrv_t'(wbits);
        end
      end
      if (mode_q == MODE_MASTER) begin
        cap_pri_q <= pri_tdo_i;
        cap_sec_q <= sec_tdo_i;
      end
    end
  end

  assign mode    = mode_q;
  assign pdrv    = pdrv_q;
  assign sdrv    = sdrv_q;
  assign cap_pri = cap_pri_q;
  assign cap_sec = cap_sec_q;

  // R12
  idle_on_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |-> (pdrv_q == DRV_IDLE && sdrv_q == DRV_IDLE));

  // R4
  mode_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |-> $past(wr_evt, 2));
endmodule

// File: rtl/jms_router.sv
module jms_router
  import jms_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      toe_n,
  input  jms_mode_e mode,
  input  jdrv_t     pdrv,
  input  jdrv_t     sdrv,
  input  jdrv_t     pri_in,
  input  logic      sec_tdo_i,
  input  logic      pri_awr_n_i,
  output jdrv_t     pri_out,
  output logic      pri_tdo_o,
  output logic      pri_ctl_oe,
  output logic      pri_tdo_oe,
  output jdrv_t     sec_out,
  output logic      sec_awr_n_o,
  output logic      sec_oe,
  output logic      slave_n,
  output logic      master_n,
  output logic      pri_tdo_drv_n,
  output logic      misc_oe
);
  logic is_master;
  assign is_master = (mode == MODE_MASTER);

  assign pri_out       = pdrv;
  assign pri_tdo_o     = sec_tdo_i;
  assign pri_ctl_oe    = is_master & toe_n;
  assign pri_tdo_oe    = ~is_master & toe_n;
  assign sec_out       = is_master ? sdrv : pri_in;
  assign sec_awr_n_o   = is_master | pri_awr_n_i;
  assign sec_oe        = toe_n;
  assign misc_oe       = toe_n;
  assign slave_n       = is_master;
  assign master_n      = ~is_master;
  assign pri_tdo_drv_n = is_master;

  // R3
  tdi_tdo_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pri_ctl_oe && pri_tdo_oe));

  // R10
  toe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !toe_n |-> !(pri_ctl_oe || pri_tdo_oe || sec_oe || misc_oe));

  // R8
  drv_strobe_slave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pri_tdo_drv_n |-> !slave_n);

  // R7
  status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({slave_n, master_n}) == 1);
endmodule

// File: rtl/jtag_mode_switch.sv
module jtag_mode_switch
  import jms_pkg::*;
#(
  parameter int unsigned AW          = 4,
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          toe_n,
  input  logic          host_cs_n,
  input  logic          host_rd_n,
  input  logic          host_wr_n,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_rdata_oe,
  input  logic          pri_tck_i,
  input  logic          pri_tms_i,
  input  logic          pri_tdi_i,
  input  logic          pri_trst_i,
  input  logic          pri_tdo_i,
  output logic          pri_tck_o,
  output logic          pri_tms_o,
  output logic          pri_tdi_o,
  output logic          pri_trst_o,
  output logic          pri_tdo_o,
  output logic          pri_ctl_oe,
  output logic          pri_tdo_oe,
  input  logic          pri_awr_n_i,
  output logic          sec_tck_o,
  output logic          sec_tms_o,
  output logic          sec_tdi_o,
  output logic          sec_trst_o,
  input  logic          sec_tdo_i,
  output logic          sec_awr_n_o,
  output logic          sec_oe,
  output logic          slave_n,
  output logic          master_n,
  output logic          pri_tdo_drv_n,
  output logic          misc_oe
);
  localparam int unsigned DRV_W = $bits(jdrv_t);

  logic      wr_evt, rd_act;
  jms_mode_e mode;
  jdrv_t     pdrv, sdrv, pri_in, pri_out, sec_out;
  logic      cap_pri, cap_sec;
  logic      unused_wdata;

  assign unused_wdata = ^host_wdata[DW-1:DRV_W];

  jms_host_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (host_cs_n),
    .rd_n   (host_rd_n),
    .wr_n   (host_wr_n),
    .wr_evt (wr_evt),
    .rd_act (rd_act)
  );

  jms_mode_regs #(.AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_evt    (wr_evt),
    .addr      (host_addr),
    .wbits     (host_wdata[DRV_W-1:0]),
    .pri_tdo_i (pri_tdo_i),
    .sec_tdo_i (sec_tdo_i),
    .mode      (mode),
    .pdrv      (pdrv),
    .sdrv      (sdrv),
    .cap_pri   (cap_pri),
    .cap_sec   (cap_sec)
  );

  assign pri_in = '{trst: pri_trst_i, tdi: pri_tdi_i, tms: pri_tms_i, tck: pri_tck_i};

  jms_router u_route (
    .clk           (clk),
    .rst_n         (rst_n),
    .toe_n         (toe_n),
    .mode          (mode),
    .pdrv          (pdrv),
    .sdrv          (sdrv),
    .pri_in        (pri_in),
    .sec_tdo_i     (sec_tdo_i),
    .pri_awr_n_i   (pri_awr_n_i),
    .pri_out       (pri_out),
    .pri_tdo_o     (pri_tdo_o),
    .pri_ctl_oe    (pri_ctl_oe),
    .pri_tdo_oe    (pri_tdo_oe),
    .sec_out       (sec_out),
    .sec_awr_n_o   (sec_awr_n_o),
    .sec_oe        (sec_oe),
    .slave_n       (slave_n),
    .master_n      (master_n),
    .pri_tdo_drv_n (pri_tdo_drv_n),
    .misc_oe       (misc_oe)
  );

  assign pri_tck_o  = pri_out.tck;
  assign pri_tms_o  = pri_out.tms;
  assign pri_tdi_o  = pri_out.tdi;
  assign pri_trst_o = pri_out.trst;
  assign sec_tck_o  = sec_out.tck;
  assign sec_tms_o  = sec_out.tms;
  assign sec_tdi_o  = sec_out.tdi;
  assign sec_trst_o = sec_out.trst;

  always_comb begin
    host_rdata = '0;
    if (host_addr == AW'(REG_MODE)) begin
      host_rdata[0] = (mode == MODE_MASTER);
    end else if (host_addr == AW'(REG_PDRV)) begin
      host_rdata[DRV_W-1:0] = pdrv;
    end else if (host_addr == AW'(REG_SDRV)) begin
      host_rdata[DRV_W-1:0] = sdrv;
    end else if (host_addr == AW'(REG_STAT)) begin
      host_rdata[2:0] = {mode == MODE_MASTER, cap_sec, cap_pri};
    end
  end

  assign host_rdata_oe = rd_act & toe_n;

  // R10
  rdata_toe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !toe_n |-> !host_rdata_oe);
endmodule

// File: tb/jtag_mode_switch_bench.sv
module jtag_mode_switch_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic toe_n = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic rdata_oe;
  logic p_tck_i = 0, p_tms_i = 0, p_tdi_i = 0, p_trst_i = 0, p_tdo_i = 0;
  logic p_tck_o, p_tms_o, p_tdi_o, p_trst_o, p_tdo_o, p_ctl_oe, p_tdo_oe;
  logic p_awr_n = 1'b1;
  logic s_tck_o, s_tms_o, s_tdi_o, s_trst_o, s_tdo_i = 0, s_awr_n_o, s_oe;
  logic slave_n, master_n, drv_n, misc_oe;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  jtag_mode_switch u_jtag_mode_switch (
    .clk(clk), .rst_n(rst_n), .toe_n(toe_n),
    .host_cs_n(cs_n), .host_rd_n(rd_n), .host_wr_n(wr_n),
    .host_addr(addr), .host_wdata(wdata), .host_rdata(rdata), .host_rdata_oe(rdata_oe),
    .pri_tck_i(p_tck_i), .pri_tms_i(p_tms_i), .pri_tdi_i(p_tdi_i), .pri_trst_i(p_trst_i),
    .pri_tdo_i(p_tdo_i), .pri_tck_o(p_tck_o), .pri_tms_o(p_tms_o), .pri_tdi_o(p_tdi_o),
    .pri_trst_o(p_trst_o), .pri_tdo_o(p_tdo_o), .pri_ctl_oe(p_ctl_oe), .pri_tdo_oe(p_tdo_oe),
    .pri_awr_n_i(p_awr_n), .sec_tck_o(s_tck_o), .sec_tms_o(s_tms_o), .sec_tdi_o(s_tdi_o),
    .sec_trst_o(s_trst_o), .sec_tdo_i(s_tdo_i), .sec_awr_n_o(s_awr_n_o), .sec_oe(s_oe),
    .slave_n(slave_n), .master_n(master_n), .pri_tdo_drv_n(drv_n), .misc_oe(misc_oe)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected secondary outputs {trst,tdi,tms,tck}
  function automatic logic [3:0] exp_sec(bit master, logic [3:0] sreg, logic [3:0] pins);
    return master ? sreg : pins;
  endfunction

  function automatic logic [3:0] pri_pins();
    return {p_trst_i, p_tdi_i, p_tms_i, p_tck_i};
  endfunction

  task automatic host_write(logic [3:0] a, logic [7:0] d, bit use_cs);
    @(negedge clk);
    addr = a; wdata = d; cs_n = !use_cs; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic host_read(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; cs_n = 1'b0; rd_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R11 rdata_oe", rdata_oe, 1);
    d = rdata;
    cs_n = 1'b1; rd_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // mode write that also watches the pins in the last cycle before the switch
  task automatic mode_write_watch(bit to_master);
    logic [3:0] last_pri;
    logic last_m;
    bit seen;
    seen = 0;
    @(negedge clk);
    addr = 4'h0; wdata = {7'd0, to_master}; cs_n = 1'b0; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    last_m = master_n;
    last_pri = {p_trst_o, p_tdi_o, p_tms_o, p_tck_o};
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (master_n !== last_m && !seen) begin
        seen = 1;
        // R12: pins at idle in the cycle before the direction change
        check("R12 idle before switch", last_pri, 4'b1110);
      end
      last_m = master_n;
      last_pri = {p_trst_o, p_tdi_o, p_tms_o, p_tck_o};
    end
    check("R12 switch seen", seen, 1);
  endtask

  task automatic slave_pattern(int reps);
    for (int i = 0; i < reps; i++) begin
      @(negedge clk);
      {p_trst_i, p_tdi_i, p_tms_i, p_tck_i} = 4'($urandom);
      s_tdo_i = 1'($urandom);
      p_awr_n = 1'($urandom);
      #2;
      check("R2 pass-through", {s_trst_o, s_tdi_o, s_tms_o, s_tck_o}, exp_sec(0, 4'h0, pri_pins()));
      check("R3 tdo return", p_tdo_o, s_tdo_i);
      check("R9 awr forward", s_awr_n_o, p_awr_n);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] rd;
    logic [3:0] pv, sv;
    void'($urandom(32'h1c0ffee));
    repeat (4) @(negedge clk);
    // R1: state while held in reset
    check("R1 slave in reset", slave_n, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 slave after reset", slave_n, 0);
    check("R7 master_n high", master_n, 1);
    check("R3 tdo_oe", p_tdo_oe, 1);
    check("R3 ctl_oe off", p_ctl_oe, 0);
    check("R8 drive strobe", drv_n, 0);
    host_read(4'h1, rd); check("R1 pdrv idle", rd, 8'h0E);
    host_read(4'h2, rd); check("R1 sdrv idle", rd, 8'h0E);
    host_read(4'h0, rd); check("R1 mode reg", rd, 8'h00);

    slave_pattern(20);

    // R4: writes that must not enter master mode
    host_write(4'h0, 8'hFE, 1);
    check("R4 bit0=0 write", slave_n, 0);
    host_write(4'h0, 8'h01, 0);
    check("R4 cs_n high write", slave_n, 0);
    host_write(4'h3, 8'hFF, 1);
    check("R4 other addr write", slave_n, 0);
    host_write(4'h1, 8'h05, 1);
    host_read(4'h1, rd); check("R12 pdrv readback", rd, 8'h05);
    check("R4 still slave", master_n, 1);

    // enter master
    mode_write_watch(1);
    check("R7 master_n low", master_n, 0);
    check("R7 slave_n high", slave_n, 1);
    check("R5 ctl_oe", p_ctl_oe, 1);
    check("R5 tdo_oe off", p_tdo_oe, 0);
    check("R8 strobe off in master", drv_n, 1);
    host_read(4'h1, rd); check("R12 pdrv forced idle", rd, 8'h0E);
    host_read(4'h0, rd); check("R12 mode reg master", rd, 8'h01);

    for (int i = 0; i < 12; i++) begin
      pv = 4'($urandom);
      sv = 4'($urandom);
      host_write(4'h1, {4'($urandom), pv}, 1);
      host_write(4'h2, {4'($urandom), sv}, 1);
      @(negedge clk);
      {p_trst_i, p_tdi_i, p_tms_i, p_tck_i} = 4'($urandom);
      p_awr_n = 1'($urandom);
      p_tdo_i = 1'($urandom);
      s_tdo_i = 1'($urandom);
      #2;
      check("R5 primary drive", {p_trst_o, p_tdi_o, p_tms_o, p_tck_o}, pv);
      check("R6 secondary drive", {s_trst_o, s_tdi_o, s_tms_o, s_tck_o}, exp_sec(1, sv, pri_pins()));
      check("R9 awr held high", s_awr_n_o, 1);
      host_read(4'h3, rd);
      check("R11 status reg", rd, {5'd0, 1'b1, s_tdo_i, p_tdo_i});
    end

    // R10: global output disable
    @(negedge clk);
    toe_n = 1'b0;
    addr = 4'h3; cs_n = 1'b0; rd_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 all oe off", {p_ctl_oe, p_tdo_oe, s_oe, misc_oe, rdata_oe}, 5'b0);
    cs_n = 1'b1; rd_n = 1'b1; toe_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 oe restored", {p_ctl_oe, s_oe, misc_oe}, 3'b111);

    // back to slave with non-idle primary drive
    host_write(4'h1, 8'h01, 1);
    @(negedge clk);
    check("R5 tck high before exit", p_tck_o, 1);
    mode_write_watch(0);
    check("R1 slave again", slave_n, 0);
    host_read(4'h2, rd); check("R12 sdrv idle after exit", rd, 8'h0E);
    slave_pattern(10);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule